// File: doc/BRIEF.md
# SPI Master Serial Shift Engine

This block is the serial core of a single-target SPI master. It accepts one parallel word at a time through a valid/ready handshake. While the word is in flight it drives the serial clock and the frame (chip-select) line. It shifts the word out on `mosi` and, in the same frame, assembles an equally long word from `miso`. When the frame ends, the received word is presented with a one-cycle valid strobe.

The serial clock comes from an even divider of the system clock. The bus timing is not chosen as a single clock-polarity/phase pair. It is set by four separate controls:
- the level the clock rests at between frames;
- the clock edge on which incoming data is sampled;
- an optional delay before the first clock edge;
- a frame-start selector that sets the length of that delay.

Together these controls reach all four conventional SPI modes. Word length runs from 1 to 32 bits, sent either most-significant or least-significant bit first. A global enable stops a frame at once and parks the lines.

Top module: `spi_shift_master`

## Requirements
- R1: The clock half-period is H = max(clkDiv with bit 0 cleared, 4) / 2 system cycles. An odd divider acts like the next lower even value. The divider is captured when a word is accepted, so changing `clkDiv` during a frame has no effect on that frame.
- R2: Outside a frame, `frameOut` sits at the inactive level (the inverse of `framePol`). `sclk` follows `idleLevel` with one cycle of delay.
- R3: While `busy` is high, `frameOut` equals `framePol` (1 = active high, 0 = active low).
- R4: `txReady` is high exactly when `enable` is high and `busy` is low. A word is accepted on a clock edge where `txValid` and `txReady` are both high, and `busy` is high in the following cycle.
- R5: The first `sclk` edge comes L cycles after the accepting edge. L = H when `leadDelay` is 0, L = 2H when `leadDelay` is 1 and `frameStart` is 1, and L = 3H when `leadDelay` is 1 and `frameStart` is 0.
- R6: A frame has exactly 2·N `sclk` edges, where N is the word length, spaced H cycles apart. The frame ends H cycles after the last edge, with `sclk` back at its resting level.
- R7: `miso` is sampled on capture edges: rising when `capEdge` is 0, falling when `capEdge` is 1. The first `mosi` bit is driven from the start of the frame. `mosi` moves to the next bit on every non-capture edge that follows at least one capture edge.
- R8: `wordLenM1` holds the word length minus one (5 bits: 0 means 1 bit, 31 means 32 bits).
- R9: The 2-bit `bitOrder` field selects LSB-first when it equals 1; values 0, 2 and 3 select MSB-first. `rxData` is right-justified, with all bits at and above the word length set to zero.
- R10: `rxValid` is high for exactly one cycle: the cycle in which `busy` falls and the frame ends. `rxData` holds the received word until the next completion.
- R11: While `enable` is low, any frame in progress is abandoned without an `rxValid`, `frameOut` is inactive, `sclk` is at `idleLevel` and `txReady` is low. If `enable` is low on the same edge at which a frame would have completed, the abort wins.
- R12: The four conventional modes are reached with these settings of (capEdge, idleLevel, leadDelay, frameStart): (1,0,1,0), (0,0,0,1), (0,1,1,1) and (1,1,0,0). Each one exchanges words correctly with a target that follows the R7 sampling and launch rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Global run enable |
| txData | input | 32 | Word to transmit, right-justified |
| txValid | input | 1 | Transmit word offered |
| txReady | output | 1 | Engine can take a word |
| wordLenM1 | input | 5 | Word length minus one |
| bitOrder | input | 2 | Bit order field (1 = LSB first) |
| clkDiv | input | 8 | Serial clock divider |
| capEdge | input | 1 | Capture edge (0 rising, 1 falling) |
| idleLevel | input | 1 | Resting level of the serial clock |
| leadDelay | input | 1 | Add delay before the first clock edge |
| frameStart | input | 1 | Frame-start selector; sets the delay length |
| framePol | input | 1 | Active level of the frame line |
| sclk | output | 1 | Serial clock |
| frameOut | output | 1 | Frame (chip-select) line |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| rxData | output | 32 | Received word, right-justified |
| rxValid | output | 1 | One-cycle strobe when a word completes |
| busy | output | 1 | A frame is in progress |

## Verification
A frame can complete on the same clock edge where `enable` drops, so the abort path and the completion path meet in one cycle. The bench provokes this from the R5/R6 arithmetic. For a 2-bit word with H = 2 and no lead delay, completion lands on the tenth edge after acceptance. The bench drops `enable` just before that edge in one run and just after it in a second run. The first run must produce no `rxValid` and leave the frame inactive. The second run must deliver the word. A second meeting point, completion and the next acceptance in back-to-back cycles, is judged by holding `txValid` high and requiring `txReady` in the strobe cycle and `busy` in the cycle after.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // Strobes issued by the control sequencer to the shift datapath.
  typedef struct packed {
    logic load;     // new word accepted this cycle
    logic capture;  // sample miso on this serial edge
    logic advance;  // present next mosi bit on this serial edge
    logic finish;   // frame ends, publish received word
  } spimStrobe_t;

endpackage

// File: rtl/spim_control.sv
module spim_control
  import spim_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             txValid,
  output logic             txReady,
  input  logic [LEN_W-1:0] lenM1,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             capSel,
  input  logic             idleLvl,
  input  logic             dlySel,
  input  logic             startSel,
  output logic             sclk,
  output logic             active,
  output logic             rxValid,
  output spimStrobe_t      strobe
);

  localparam int CNT_W  = DIV_W + 2;
  localparam int EDGE_W = LEN_W + 2;
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(4);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT} spimState_t;

  spimState_t        state;
  logic [CNT_W-1:0]  timer;
  logic [CNT_W-1:0]  halfR;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] edgeTotal;
  logic              capR;
  logic              seenCap;
  logic              sclkR;
  logic              rxValidR;

  logic [DIV_W-1:0]  evenDiv;
  logic [CNT_W-1:0]  halfIn;
  logic [CNT_W-1:0]  leadIn;
  logic              tick;
  logic              newLvl;
  logic              edgeIsCap;
  logic              lastDone;
  logic              doEdge;
  logic              accept;

  // Divider rounding and lead length, evaluated at acceptance.
  always_comb begin
    evenDiv = clkDiv & ~DIV_W'(1);
    if (evenDiv < MIN_DIV) evenDiv = MIN_DIV;
    halfIn = CNT_W'(evenDiv >> 1);
    leadIn = halfIn;
    if (dlySel) begin
      if (startSel) leadIn = halfIn + halfIn;
      else          leadIn = halfIn + halfIn + halfIn;
    end
  end

  assign accept    = enable && txValid && (state == S_IDLE);
  assign tick      = (timer == '0);
  assign newLvl    = ~sclkR;
  assign edgeIsCap = newLvl ^ capR;
  assign lastDone  = (edgeCnt == edgeTotal);
  assign doEdge    = enable && tick &&
                     ((state == S_LEAD) || ((state == S_SHIFT) && !lastDone));

  always_comb begin
    strobe.load    = accept;
    strobe.capture = doEdge && edgeIsCap;
    strobe.advance = doEdge && !edgeIsCap && seenCap;
    strobe.finish  = enable && tick && (state == S_SHIFT) && lastDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      timer     <= '0;
      halfR     <= '0;
      edgeCnt   <= '0;
      edgeTotal <= '0;
      capR      <= 1'b0;
      seenCap   <= 1'b0;
      sclkR     <= 1'b0;
      rxValidR  <= 1'b0;
    end else begin
      rxValidR <= 1'b0;
      if (!enable) begin
        state <= S_IDLE;
        sclkR <= idleLvl;
      end else begin
        unique case (state)
          S_IDLE: begin
            sclkR <= idleLvl;
            if (txValid) begin
              state     <= S_LEAD;
              timer     <= leadIn - CNT_W'(1);
              halfR     <= halfIn;
              edgeCnt   <= '0;
              edgeTotal <= EDGE_W'((EDGE_W'(lenM1) + EDGE_W'(1)) << 1);
              capR      <= capSel;
              seenCap   <= 1'b0;
            end
          end
          S_LEAD, S_SHIFT: begin
            if (!tick) begin
              timer <= timer - CNT_W'(1);
            end else if ((state == S_SHIFT) && lastDone) begin
              state    <= S_IDLE;
              rxValidR <= 1'b1;
            end else begin
              state   <= S_SHIFT;
              sclkR   <= newLvl;
              edgeCnt <= edgeCnt + EDGE_W'(1);
              timer   <= halfR - CNT_W'(1);
              if (edgeIsCap) seenCap <= 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign txReady = enable && (state == S_IDLE);
  assign active  = (state != S_IDLE);
  assign sclk    = sclkR;
  assign rxValid = rxValidR;

endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  spimStrobe_t       strobe,
  input  logic [DATA_W-1:0] txData,
  input  logic [LEN_W-1:0]  lenM1,
  input  logic [1:0]        orderSel,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData
);

  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxAcc;
  logic [DATA_W-1:0] rxOut;
  logic [LEN_W-1:0]  lenR;
  logic [LEN_W-1:0]  rxIdx;
  logic              lsbR;
  logic              lsbIn;
  logic [DATA_W-1:0] maskTx;
  logic [DATA_W-1:0] revTx;
  logic [LEN_W-1:0]  rxPos;

  assign lsbIn = (orderSel == 2'd1);

  // Masked and length-reversed images of the offered word; bit 0 leaves first.
  always_comb begin
    maskTx = '0;
    revTx  = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (LEN_W'(i) <= lenM1) begin
        maskTx[i] = txData[i];
        revTx[i]  = txData[lenM1 - LEN_W'(i)];
      end
    end
  end

  assign rxPos = lsbR ? rxIdx : (lenR - rxIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxAcc   <= '0;
      rxOut   <= '0;
      lenR    <= '0;
      rxIdx   <= '0;
      lsbR    <= 1'b0;
    end else begin
      if (strobe.load) begin
        txShift <= lsbIn ? maskTx : revTx;
        rxAcc   <= '0;
        rxIdx   <= '0;
        lenR    <= lenM1;
        lsbR    <= lsbIn;
      end else begin
        if (strobe.advance) txShift <= txShift >> 1;
        if (strobe.capture) begin
          rxAcc[rxPos] <= miso;
          rxIdx        <= rxIdx + LEN_W'(1);
        end
        if (strobe.finish) rxOut <= rxAcc;
      end
    end
  end

  assign mosi   = txShift[0];
  assign rxData = rxOut;

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spim_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enable,
  input  logic [DATA_W-1:0]         txData,
  input  logic                      txValid,
  output logic                      txReady,
  input  logic [$clog2(DATA_W)-1:0] wordLenM1,
  input  logic [1:0]                bitOrder,
  input  logic [DIV_W-1:0]          clkDiv,
  input  logic                      capEdge,
  input  logic                      idleLevel,
  input  logic                      leadDelay,
  input  logic                      frameStart,
  input  logic                      framePol,
  output logic                      sclk,
  output logic                      frameOut,
  output logic                      mosi,
  input  logic                      miso,
  output logic [DATA_W-1:0]         rxData,
  output logic                      rxValid,
  output logic                      busy
);

  localparam int LEN_W = $clog2(DATA_W);

  spimStrobe_t strobe;
  logic        active;

  spim_control #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .txValid  (txValid),
    .txReady  (txReady),
    .lenM1    (wordLenM1),
    .clkDiv   (clkDiv),
    .capSel   (capEdge),
    .idleLvl  (idleLevel),
    .dlySel   (leadDelay),
    .startSel (frameStart),
    .sclk     (sclk),
    .active   (active),
    .rxValid  (rxValid),
    .strobe   (strobe)
  );

  spim_datapath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .txData   (txData),
    .lenM1    (wordLenM1),
    .orderSel (bitOrder),
    .miso     (miso),
    .mosi     (mosi),
    .rxData   (rxData)
  );

  assign frameOut = active ? framePol : ~framePol;
  assign busy     = active;

endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic txReady,
  input logic busy,
  input logic rxValid,
  input logic sclk,
  input logic frameOut,
  input logic framePol,
  input logic idleLevel
);

  // R10: completion strobe lasts one cycle
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R10: completion coincides with the end of busy
  p_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $fell(busy));

  // R4: no new word is offered a ready while a frame runs
  p_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !txReady);

  // R3: frame line at its active level during a frame
  p_active_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (frameOut == framePol));

  // R11: disabling parks the engine in the next cycle
  p_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ((frameOut != framePol) && !rxValid && !busy));

  // R2: resting clock follows the idle-level input
  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && $past(rstN)) |-> (sclk == $past(idleLevel)));

endmodule

bind spi_shift_master spi_shift_master_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .txReady   (txReady),
  .busy      (busy),
  .rxValid   (rxValid),
  .sclk      (sclk),
  .frameOut  (frameOut),
  .framePol  (framePol),
  .idleLevel (idleLevel)
);

// File: tb/sim_spi_shift_master.sv
module sim_spi_shift_master;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b1;
  logic [31:0] txData = '0;
  logic        txValid = 1'b0;
  logic        txReady;
  logic [4:0]  wordLenM1 = '0;
  logic [1:0]  bitOrder = '0;
  logic [7:0]  clkDiv = 8'd4;
  logic        capEdge = 1'b0;
  logic        idleLevel = 1'b0;
  logic        leadDelay = 1'b0;
  logic        frameStart = 1'b0;
  logic        framePol = 1'b0;
  logic        sclk;
  logic        frameOut;
  logic        mosi;
  logic        miso = 1'b0;
  logic [31:0] rxData;
  logic        rxValid;
  logic        busy;

  always #2 clk = ~clk;  // 250 MHz

  spi_shift_master u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .txData(txData), .txValid(txValid),
    .txReady(txReady), .wordLenM1(wordLenM1), .bitOrder(bitOrder), .clkDiv(clkDiv),
    .capEdge(capEdge), .idleLevel(idleLevel), .leadDelay(leadDelay),
    .frameStart(frameStart), .framePol(framePol), .sclk(sclk), .frameOut(frameOut),
    .mosi(mosi), .miso(miso), .rxData(rxData), .rxValid(rxValid), .busy(busy)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---- target model and frame monitor ----
  logic [31:0] slvWord = '0;
  int          curLen = 1;
  bit          curLsb = 0;
  int          cyc = 0, edges = 0, firstEdge = -1, secondEdge = -1;
  int          capCnt = 0, sIdx = 0, doneCyc = 0;
  bit          seenCap = 0, gotValid = 0, prevOn = 0;
  logic        prevSclk = 1'b0;
  logic [31:0] gotMosi = '0, gotRx = '0;

  function automatic logic slvBit(input int i);
    if (i >= curLen) return 1'b0;
    return curLsb ? slvWord[i] : slvWord[curLen-1-i];
  endfunction

  function automatic logic [31:0] maskOf(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
  endfunction

  function automatic int halfOf(input int div);
    int e;
    e = div & 'hFE;
    if (e < 4) e = 4;
    return e / 2;
  endfunction

  function automatic int leadOf(input int h, input bit dly, input bit st);
    if (!dly) return h;
    return st ? 2 * h : 3 * h;
  endfunction

  always @(negedge clk) begin
    bit on;
    int pos;
    on = (frameOut == framePol);
    if (on && !prevOn) begin
      cyc = 0; edges = 0; firstEdge = -1; secondEdge = -1;
      capCnt = 0; sIdx = 0; seenCap = 0; gotMosi = '0;
      miso = slvBit(0);
    end else if (on) begin
      cyc++;
      if (sclk !== prevSclk) begin
        edges++;
        if (edges == 1) firstEdge = cyc;
        if (edges == 2) secondEdge = cyc;
        if ((sclk ^ capEdge) == 1'b1) begin
          pos = curLsb ? capCnt : (curLen - 1 - capCnt);
          if (capCnt < curLen) gotMosi[pos] = mosi;
          capCnt++;
          seenCap = 1;
        end else if (seenCap) begin
          sIdx++;
          miso = slvBit(sIdx);
        end
      end
    end
    if (rxValid) begin
      gotValid = 1;
      gotRx = rxData;
      doneCyc = cyc + 1;
    end
    prevOn = on;
    prevSclk = sclk;
  end

  // ---- stimulus helpers ----
  task automatic startWord(input logic [31:0] tx, input logic [31:0] sw, input int len,
                           input logic [1:0] ord, input int div, input bit cap, input bit idl,
                           input bit dly, input bit st, input bit pol, input int divAfter);
    @(negedge clk);
    txData = tx; slvWord = sw; curLen = len; curLsb = (ord == 2'd1);
    wordLenM1 = 5'(len - 1); bitOrder = ord; clkDiv = 8'(div);
    capEdge = cap; idleLevel = idl; leadDelay = dly; frameStart = st; framePol = pol;
    gotValid = 0;
    @(negedge clk);            // inputs settle one cycle at idle
    txValid = 1'b1;
    @(negedge clk);            // accepted on the edge just passed
    txValid = 1'b0;
    clkDiv = 8'(divAfter);
    chk(busy == 1'b1 && txReady == 1'b0, "R4", "busy after accept", {busy, txReady}, 2'b10);
    chk(frameOut == pol, "R3", "frame active level", frameOut, pol);
  endtask

  task automatic runWord(input logic [31:0] tx, input logic [31:0] sw, input int len,
                         input logic [1:0] ord, input int div, input bit cap, input bit idl,
                         input bit dly, input bit st, input bit pol, input int divAfter,
                         input string tag);
    int h, ld;
    logic [31:0] m;
    startWord(tx, sw, len, ord, div, cap, idl, dly, st, pol, divAfter);
    for (int i = 0; i < 20000 && !gotValid; i++) @(negedge clk);
    h = halfOf(div); ld = leadOf(h, dly, st); m = maskOf(len);
    chk(gotValid == 1, tag, "word completed", gotValid, 1);
    chk(gotRx == (sw & m), tag, "R7 R9 received word", gotRx, sw & m);
    chk(gotMosi == (tx & m), tag, "R7 R9 sent word", gotMosi, tx & m);
    chk(edges == 2 * len, tag, "R6 edge count", edges, 2 * len);
    chk(firstEdge == ld, tag, "R5 lead cycles", firstEdge, ld);
    chk(secondEdge - firstEdge == h, tag, "R1 half period", secondEdge - firstEdge, h);
    chk(doneCyc == ld + 2 * len * h, tag, "R6 R10 completion cycle", doneCyc, ld + 2 * len * h);
    @(negedge clk);
    chk(sclk == idl && frameOut == ~pol && busy == 1'b0, tag, "R2 rest state",
        {sclk, frameOut, busy}, {idl, ~pol, 1'b0});
  endtask

  // ---- watchdog ----
  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---- main sequence ----
  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(txReady == 1'b1 && busy == 1'b0 && rxValid == 1'b0, "R4", "reset state",
        {txReady, busy, rxValid}, 3'b100);
    chk(frameOut == ~framePol && sclk == idleLevel, "R2", "reset lines", {frameOut, sclk}, {~framePol, idleLevel});

    // R2: resting clock tracks idle-level input
    idleLevel = 1'b1; @(negedge clk);
    chk(sclk == 1'b1, "R2", "idle high", sclk, 1);
    idleLevel = 1'b0; @(negedge clk);
    chk(sclk == 1'b0, "R2", "idle low", sclk, 0);

    // R12: the four conventional modes
    runWord(32'hA5, 32'h3C, 8, 2'd0, 4, 1, 0, 1, 0, 0, 4, "R12");
    runWord(32'h5A, 32'hC3, 8, 2'd0, 4, 0, 0, 0, 1, 0, 4, "R12");
    runWord(32'h96, 32'h69, 8, 2'd0, 4, 0, 1, 1, 1, 0, 4, "R12");
    runWord(32'h1E, 32'hE1, 8, 2'd0, 4, 1, 1, 0, 0, 0, 4, "R12");

    // R8: shortest and longest words
    runWord(32'h1, 32'h1, 1, 2'd0, 6, 0, 0, 0, 0, 1, 6, "R8");
    runWord(32'hDEADBEEF, 32'h12345678, 32, 2'd0, 4, 0, 0, 1, 1, 1, 4, "R8");

    // R9: order field values
    runWord(32'h0123, 32'h0F0F, 12, 2'd1, 4, 0, 0, 0, 0, 0, 4, "R9");
    runWord(32'h0456, 32'h00F3, 12, 2'd2, 4, 1, 1, 0, 0, 0, 4, "R9");
    runWord(32'hFFFF_FF81, 32'hFFFF_FF3E, 7, 2'd3, 4, 0, 0, 0, 0, 1, 4, "R9");

    // R1: odd divider, too-small divider, largest divider, change during frame
    runWord(32'h2B, 32'h4D, 6, 2'd0, 7, 0, 0, 0, 0, 0, 7, "R1");
    runWord(32'h3, 32'h2, 2, 2'd1, 2, 0, 0, 0, 0, 0, 2, "R1");
    runWord(32'h2, 32'h1, 2, 2'd0, 254, 1, 0, 1, 0, 0, 254, "R1");
    runWord(32'h9C, 32'h63, 8, 2'd0, 6, 0, 0, 0, 0, 0, 20, "R1");

    // R11: abort mid-frame
    startWord(32'hBEEF, 32'hCAFE, 16, 2'd0, 8, 0, 1, 0, 0, 0, 8);
    repeat (30) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(frameOut == 1'b1 && sclk == 1'b1 && busy == 1'b0 && txReady == 1'b0, "R11",
        "abort lines", {frameOut, sclk, busy, txReady}, 4'b1100);
    repeat (200) @(negedge clk);
    chk(gotValid == 0, "R11", "no strobe after abort", gotValid, 0);
    enable = 1'b1;
    @(negedge clk);
    chk(txReady == 1'b1, "R11", "ready after re-enable", txReady, 1);

    // R11: disable on the completion edge (t0+10 for 2 bits, H=2, no delay)
    startWord(32'h2, 32'h3, 2, 2'd0, 4, 0, 0, 0, 0, 0, 4);
    repeat (9) @(negedge clk);
    enable = 1'b0;
    repeat (20) @(negedge clk);
    chk(gotValid == 0 && frameOut == 1'b1, "R11", "abort wins at completion", {gotValid, frameOut}, 2'b01);
    enable = 1'b1;

    // R10: disable one cycle after completion; word is delivered
    startWord(32'h1, 32'h2, 2, 2'd0, 4, 0, 0, 0, 0, 0, 4);
    repeat (10) @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk(gotValid == 1 && gotRx == 32'h2, "R10", "completion before disable", gotRx, 32'h2);
    enable = 1'b1;

    // R4: back-to-back words with txValid held
    @(negedge clk);
    txData = 32'h9; slvWord = 32'h6; curLen = 4; curLsb = 0;
    wordLenM1 = 5'd3; bitOrder = 2'd0; clkDiv = 8'd4; capEdge = 0; idleLevel = 0;
    leadDelay = 0; frameStart = 0; framePol = 0;
    @(negedge clk);
    txValid = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2000 && !rxValid; i++) @(negedge clk);
    chk(rxValid == 1'b1 && txReady == 1'b1, "R4", "ready in strobe cycle", {rxValid, txReady}, 2'b11);
    chk(rxData == 32'h6, "R10", "back-to-back first word", rxData, 32'h6);
    @(negedge clk);
    chk(busy == 1'b1, "R4", "next word accepted at once", busy, 1);
    txValid = 1'b0;
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    @(negedge clk);
    chk(rxData == 32'h6, "R10", "rxData held after second word", rxData, 32'h6);

    // Random words
    for (int n = 0; n < 30; n++) begin
      logic [31:0] t, s;
      int len, div;
      t = $urandom(); s = $urandom();
      len = $urandom_range(1, 32);
      div = $urandom_range(2, 17);
      runWord(t, s, len, 2'($urandom_range(0, 3)), div, 1'($urandom()), 1'($urandom()),
              1'($urandom()), 1'($urandom()), 1'($urandom()), $urandom_range(2, 40), "R7");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule